// File: doc/BRIEF.md
# Square-Array 16x1 Static Memory

This block is a 16-bit static memory seen from outside as sixteen one-bit words. Internally the bits sit in a square of four rows by four columns. Part of the 4-bit address goes to a one-hot row decoder that raises a single wordline. The rest of the address steers a column selector, which works as a 4:1 multiplexer on reads and as a 1:4 demultiplexer on writes.

The single bidirectional data pin is split into three signals: an input, an output and an output-enable. Chip select, write enable and output enable are all active low. With chip select high the block ignores every other input and leaves the pin undriven. A write is captured on the rising clock edge. A read is combinational from the stored array. If a write and a read are requested together, the write wins and the driver stays off. A parameter picks which address pair feeds the row decoder. Stored data reads back correctly under either choice.

Top module: `sqs_sram16`

## Requirements
- R1: After reset is released, all 16 cells hold 0, and a read of any address returns 0.
- R2: When cs_n=0 and we_n=0 at a rising clock edge, the value of dat_in is stored in the cell at addr. No other cell changes.
- R3: When cs_n=0, oe_n=0 and we_n=1, dat_oe is 1 and dat_out equals the addressed cell in the same cycle. There is no register on the read path.
- R4: When cs_n=1, dat_oe is 0 and no cell changes, whatever we_n, oe_n, addr and dat_in are doing.
- R5: When cs_n=0, we_n=0 and oe_n=0 all hold together, the write of R2 takes place and dat_oe stays 0.
- R6: When oe_n=1, dat_oe is 0.
- R7: Whenever dat_oe is 0, dat_out is 0.
- R8: Each of the 16 addresses maps to its own cell. Writing a distinct pattern to all addresses reads back unchanged, with no aliasing.
- R9: Parameter ROW_FROM_HIGH=1 sends addr[3:2] to the row decoder and addr[1:0] to the column selector. ROW_FROM_HIGH=0 swaps the two pairs. R2, R3 and R8 hold under both settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock on which writes are captured |
| rst_n | input | 1 | Asynchronous active-low reset; clears the array |
| addr | input | 4 | Word address |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dat_in | input | 1 | Data pin, inbound value |
| dat_out | output | 1 | Data pin, outbound value |
| dat_oe | output | 1 | Data pin driver enable |

## Verification
Two functions of this block can land in the same cycle: a write and an output-enabled read, with both strobes low together. The bench provokes this by holding cs_n, we_n and oe_n low across a clock edge at an address whose stored value differs from dat_in. It then judges two things. First, dat_oe must stay 0 for the whole access. Second, a plain read of that address afterwards must return the new value. A second case applies the same strobes with chip select high, and the bench confirms that neither the driver nor the array reacts.

// File: rtl/sqs_pkg.sv
package sqs_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Strobe decode: deselect wins, then write, then read.
  function automatic acc_e decode_access(input logic cs_n, input logic we_n,
                                         input logic oe_n);
    if (cs_n)       return ACC_IDLE;
    else if (!we_n) return ACC_WRITE;
    else if (!oe_n) return ACC_READ;
    else            return ACC_IDLE;
  endfunction

  // Flat cell index from row and column.
  function automatic int cell_index(input int row, input int col, input int ncols);
    return row * ncols + col;
  endfunction

endpackage

// File: rtl/sqs_row_dec.sv
module sqs_row_dec #(
  parameter int ROW_W = 2,
  localparam int ROWS = 1 << ROW_W
) (
  input  logic [ROW_W-1:0] row,
  input  logic             en,
  output logic [ROWS-1:0]  wl
);
  for (genvar r = 0; r < ROWS; r++) begin : g_wl
    assign wl[r] = en && (row == ROW_W'(r));
  end
endmodule

// File: rtl/sqs_col_demux.sv
module sqs_col_demux #(
  parameter int COL_W = 2,
  localparam int COLS = 1 << COL_W
) (
  input  logic [COL_W-1:0] col,
  input  logic             en,
  output logic [COLS-1:0]  bl
);
  for (genvar c = 0; c < COLS; c++) begin : g_bl
    assign bl[c] = en && (col == COL_W'(c));
  end
endmodule

// File: rtl/sqs_cell_array.sv
module sqs_cell_array #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int CELLS = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROWS-1:0]  wl,
  input  logic [COLS-1:0]  bl,
  input  logic             din,
  output logic [CELLS-1:0] cells
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cells[IDX] <= 1'b0;
        else if (wl[r] && bl[c]) cells[IDX] <= din;
      end
    end
  end
endmodule

// File: rtl/sqs_col_mux.sv
module sqs_col_mux #(
  parameter int ROW_W = 2,
  parameter int COL_W = 2,
  localparam int ROWS  = 1 << ROW_W,
  localparam int COLS  = 1 << COL_W,
  localparam int CELLS = ROWS * COLS
) (
  input  logic [CELLS-1:0] cells,
  input  logic [ROWS-1:0]  wl,
  input  logic [COL_W-1:0] col,
  output logic             bit_out
);
  logic [COLS-1:0] row_word;

  // Wordline-gated OR of all rows, as a shared bitline would see it.
  always_comb begin
    row_word = '0;
    for (int r = 0; r < ROWS; r++) begin
      row_word = row_word | (cells[r*COLS +: COLS] & {COLS{wl[r]}});
    end
  end

  assign bit_out = row_word[col];
endmodule

// File: rtl/sqs_sram16.sv
module sqs_sram16 #(
  parameter int ROW_W = 2,
  parameter int COL_W = 2,
  parameter bit ROW_FROM_HIGH = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   cs_n,
  input  logic                   we_n,
  input  logic                   oe_n,
  input  logic                   dat_in,
  output logic                   dat_out,
  output logic                   dat_oe
);
  import sqs_pkg::*;

  localparam int AW    = ROW_W + COL_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;
  localparam int CELLS = ROWS * COLS;

  logic [ROW_W-1:0] row_sel;
  logic [COL_W-1:0] col_sel;
  acc_e             acc;
  logic             wr_fire;
  logic             rd_fire;
  logic [ROWS-1:0]  wl_wr;
  logic [ROWS-1:0]  wl_rd;
  logic [COLS-1:0]  bl_wr;
  logic [CELLS-1:0] cells;
  logic             rd_bit;

  if (ROW_FROM_HIGH) begin : g_row_hi
    assign row_sel = addr[AW-1 -: ROW_W];
    assign col_sel = addr[COL_W-1:0];
  end else begin : g_row_lo
    assign row_sel = addr[ROW_W-1:0];
    assign col_sel = addr[AW-1 -: COL_W];
  end

  assign acc     = decode_access(cs_n, we_n, oe_n);
  assign wr_fire = (acc == ACC_WRITE);
  assign rd_fire = (acc == ACC_READ);

  sqs_row_dec #(.ROW_W(ROW_W)) u_dec_wr (.row(row_sel), .en(wr_fire), .wl(wl_wr));
  sqs_row_dec #(.ROW_W(ROW_W)) u_dec_rd (.row(row_sel), .en(rd_fire), .wl(wl_rd));

  sqs_col_demux #(.COL_W(COL_W)) u_demux (.col(col_sel), .en(wr_fire), .bl(bl_wr));

  sqs_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk(clk), .rst_n(rst_n), .wl(wl_wr), .bl(bl_wr), .din(dat_in), .cells(cells)
  );

  sqs_col_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
    .cells(cells), .wl(wl_rd), .col(col_sel), .bit_out(rd_bit)
  );

  assign dat_oe  = rd_fire;
  assign dat_out = rd_fire & rd_bit;
endmodule

// File: rtl/sqs_sram16_chk.sv
module sqs_sram16_chk #(
  parameter int ROWS  = 4,
  parameter int CELLS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             dat_oe,
  input logic             dat_out,
  input logic [ROWS-1:0]  wl_wr,
  input logic [CELLS-1:0] cells
);
  // R4
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(cells));

  // R4
  desel_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dat_oe);

  // R5
  wr_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |-> !dat_oe);

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dat_oe);

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_oe |-> !dat_out);

  // R2
  single_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(cells ^ $past(cells)) <= 1);

  // R2
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wl_wr));
endmodule

bind sqs_sram16 sqs_sram16_chk #(.ROWS(ROWS), .CELLS(CELLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
  .dat_oe(dat_oe), .dat_out(dat_out), .wl_wr(wl_wr), .cells(cells)
);

// File: tb/sqs_sram16_test.sv
`timescale 1ns/1ps
module sqs_sram16_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = 4'd0;
  logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, dat_in = 1'b0;
  logic       out_h, oe_h, out_l, oe_l;
  logic       ref_mem [16];
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;

  sqs_sram16 #(.ROW_FROM_HIGH(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .dat_in(dat_in), .dat_out(out_h), .dat_oe(oe_h));

  sqs_sram16 #(.ROW_FROM_HIGH(1'b0)) uut_alt (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .dat_in(dat_in), .dat_out(out_l), .dat_oe(oe_l));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (addr %0d)", req, act, exp, addr);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // One write cycle; the edge captures it, strobes drop on the next falling edge.
  task automatic wr(input logic [3:0] a, input logic d);
    @(negedge clk);
    addr = a; dat_in = d; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    #5;
    chk("R5", oe_h, 1'b0);
    ref_mem[a] = d;
    @(posedge clk);
    idle();
  endtask

  // Combinational read on both mappings, sampled mid low phase.
  task automatic rd(input string req, input logic [3:0] a);
    @(negedge clk);
    addr = a; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    #5;
    chk({req, "/R3 oe"}, oe_h, 1'b1);
    chk({req, "/R9 hi"}, out_h, ref_mem[a]);
    chk({req, "/R9 lo"}, out_l, ref_mem[a]);
    checks++;
    if (oe_l !== 1'b1) begin
      errors++;
      $display("FAIL R9: alt dat_oe actual %b expected 1", oe_l);
    end
    idle();
  endtask

  task automatic t_reset();
    for (int a = 0; a < 16; a++) ref_mem[a] = 1'b0;
    #3;
    chk("R7 in reset", out_h, 1'b0);
    chk("R4 in reset", oe_h, 1'b0);
    for (int a = 0; a < 16; a++) rd("R1", 4'(a));
  endtask

  task automatic t_pattern(input logic inv);
    for (int a = 0; a < 16; a++) wr(4'(a), inv ^ (4'(a) == 4'd5 || (a % 3) == 0));
    for (int a = 0; a < 16; a++) rd("R8", 4'(a));
  endtask

  task automatic t_deselect();
    logic old;
    old = ref_mem[9];
    @(negedge clk);
    addr = 4'd9; dat_in = ~old; cs_n = 1'b1; we_n = 1'b0; oe_n = 1'b0;
    #5;
    chk("R4 no drive", oe_h, 1'b0);
    chk("R7 idle out", out_h, 1'b0);
    @(posedge clk);
    idle();
    rd("R4 kept", 4'd9);
  endtask

  task automatic t_clash();
    logic nv;
    nv = ~ref_mem[6];
    @(negedge clk);
    addr = 4'd6; dat_in = nv; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    #5;
    chk("R5 clash no drive", oe_h, 1'b0);
    chk("R5 clash alt", oe_l, 1'b0);
    ref_mem[6] = nv;
    @(posedge clk);
    #2;
    chk("R5 still off", oe_h, 1'b0);
    idle();
    rd("R5 written", 4'd6);
    rd("R2 neighbour", 4'd7);
  endtask

  task automatic t_oe_off();
    @(negedge clk);
    addr = 4'd0; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    #5;
    chk("R6 no drive", oe_h, 1'b0);
    chk("R7 out low", out_h, 1'b0);
    idle();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pattern(1'b0);
        t_pattern(1'b1);
        wr(4'd12, 1'b1);
        rd("R2", 4'd12);
        t_deselect();
        t_clash();
        t_oe_off();
        for (int a = 0; a < 16; a++) rd("R9 final", 4'(a));
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule